// File: doc/BRIEF.md
# Step-by-Four Up/Down Counter

This block is a synchronous 6-bit counter. Each qualifying clock edge moves its value by exactly four. A one-cycle event pulse, already synchronous to the clock, requests a move. A direction bit, sampled on the same edge, selects the sign of the move: 0 adds and 1 subtracts. The arithmetic wraps modulo 64. Because every move is a multiple of four, the two least significant bits stay at zero once the block has been reset.

Internally, a decoder turns reset, event and direction into one of four named actions on every edge:
- `ACT_CLEAR` is taken whenever reset is high, whatever the other inputs are.
- `ACT_HOLD` is taken when reset is low and no event is present.
- `ACT_INC` is taken when reset is low, an event is present and direction is 0.
- `ACT_DEC` is taken when reset is low, an event is present and direction is 1.

A step unit computes the next value for the chosen action. When the step is a power of two, the step unit adds or subtracts one on the upper field only. When it is not, the step unit does a full-width add. A register stores the result.

Top module: `stepctr_top`

## Requirements
- R1: With `rst` = 1 at a rising clock edge, `count` is 0 after that edge (synchronous, active-high reset).
- R2: Reset has priority: with `rst` = 1 and `evt` = 1 at the same edge, `count` becomes 0 and no step is taken.
- R3: With `rst` = 0 and `evt` = 0, `count` keeps its value across the edge, whatever the value of `dir`.
- R4: With `rst` = 0, `evt` = 1 and `dir` = 0 at an edge, `count` becomes the old value plus 4, modulo 64.
- R5: With `rst` = 0, `evt` = 1 and `dir` = 1 at an edge, `count` becomes the old value minus 4, modulo 64.
- R6: Counting up from 60 gives 0.
- R7: Counting down from 0 gives 60.
- R8: After reset, `count[1:0]` is always 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| evt | input | 1 | One-cycle step request |
| dir | input | 1 | Direction select: 0 adds, 1 subtracts |
| count | output | 6 | Present counter value |

## Verification
The bench drives the counter across both wrap points, 60 to 0 going up and 0 to 60 going down. A design that carried or borrowed into a seventh bit, or saturated at the ends, would show 60 or 0 where the other value belongs. The bench also asserts reset together with an event. A design that gave the event priority would output 4 or 60 instead of 0. It changes `dir` while `evt` is low to catch a counter that drifts when it should hold. Full up and down laps check the low two bits on every step, which exposes a step unit that moves by one or by two.

// File: rtl/stepctr_pkg.sv
package stepctr_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_INC   = 2'd1,
        ACT_DEC   = 2'd2,
        ACT_CLEAR = 2'd3
    } act_e;

endpackage

// File: rtl/stepctr_decode.sv
module stepctr_decode
    import stepctr_pkg::*;
(
    input  logic rst,
    input  logic evt,
    input  logic dir,
    output act_e act
);

    always_comb begin
        unique casez ({rst, evt, dir})
            3'b1??:  act = ACT_CLEAR;
            3'b00?:  act = ACT_HOLD;
            3'b010:  act = ACT_INC;
            3'b011:  act = ACT_DEC;
            default: act = ACT_HOLD;
        endcase
    end

endmodule

// File: rtl/stepctr_step.sv
module stepctr_step
    import stepctr_pkg::*;
#(
    parameter int WIDTH = 6,
    parameter int STEP  = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  act_e             act,
    output logic [WIDTH-1:0] nxt
);

    localparam int SH       = $clog2(STEP);
    localparam bit IS_POW2  = ((1 << SH) == STEP);
    localparam logic [WIDTH-1:0] STEP_W = WIDTH'(STEP);

    logic [WIDTH-1:0] up_val;
    logic [WIDTH-1:0] dn_val;

    generate
        if (IS_POW2 && (SH > 0) && (SH < WIDTH)) begin : g_field
            localparam int UW = WIDTH - SH;
            logic [UW-1:0] hi;
            assign hi     = cur[WIDTH-1:SH];
            assign up_val = {hi + UW'(1), cur[SH-1:0]};
            assign dn_val = {hi - UW'(1), cur[SH-1:0]};
        end else begin : g_full
            assign up_val = cur + STEP_W;
            assign dn_val = cur - STEP_W;
        end
    endgenerate

    always_comb begin
        unique case (act)
            ACT_HOLD:  nxt = cur;
            ACT_INC:   nxt = up_val;
            ACT_DEC:   nxt = dn_val;
            ACT_CLEAR: nxt = '0;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/stepctr_top.sv
module stepctr_top
    import stepctr_pkg::*;
#(
    parameter int WIDTH = 6,
    parameter int STEP  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic             dir,
    output logic [WIDTH-1:0] count
);

    localparam int SH      = $clog2(STEP);
    localparam bit IS_POW2 = ((1 << SH) == STEP);
    localparam logic [WIDTH-1:0] STEP_W = WIDTH'(STEP);
    localparam logic [WIDTH-1:0] TOP_V  = '1 - (STEP_W - WIDTH'(1));

    act_e             act;
    logic [WIDTH-1:0] count_q;
    logic [WIDTH-1:0] count_d;
    logic             rst_d;

    stepctr_decode u_dec (
        .rst (rst),
        .evt (evt),
        .dir (dir),
        .act (act)
    );

    stepctr_step #(.WIDTH(WIDTH), .STEP(STEP)) u_step (
        .cur (count_q),
        .act (act),
        .nxt (count_d)
    );

    // State register
    always_ff @(posedge clk) begin
        count_q <= count_d;
        rst_d   <= rst;
    end

    // Output process
    always_comb begin
        count = count_q;
    end

    always @(negedge clk) begin
        if (rst_d) begin
            AST_RESET_CLEARS: assert (count_q == '0); // R1
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(count_q)); // R3

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (evt && !dir) |=> (count_q == $past(count_q) + STEP_W)); // R4

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (evt && dir) |=> (count_q == $past(count_q) - STEP_W)); // R5

    AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        (evt && !dir && count_q == TOP_V) |=> (count_q == '0)); // R6

    AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (evt && dir && count_q == '0) |=> (count_q == TOP_V)); // R7

    generate
        if (IS_POW2 && (SH > 0) && (SH < WIDTH)) begin : g_low_chk
            AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> (count_q[SH-1:0] == '0)); // R8
        end
    endgenerate

endmodule

// File: tb/sim_stepctr_top.sv
`timescale 1ns/1ps
module sim_stepctr_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt = 1'b0;
    logic       dir = 1'b0;
    logic [5:0] count;

    int n_run  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    stepctr_top u0 (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .dir   (dir),
        .count (count)
    );

    // {rst, evt, dir, expected count after the edge}
    localparam int NV = 15;
    localparam logic [8:0] VEC [NV] = '{
        {3'b100, 6'd0},   // R1 reset state
        {3'b010, 6'd4},   // R4
        {3'b010, 6'd8},   // R4
        {3'b001, 6'd8},   // R3 dir moves, no event
        {3'b011, 6'd4},   // R5
        {3'b011, 6'd0},   // R5
        {3'b011, 6'd60},  // R7 wrap down
        {3'b010, 6'd0},   // R6 wrap up
        {3'b011, 6'd60},  // R7
        {3'b011, 6'd56},  // R5
        {3'b000, 6'd56},  // R3
        {3'b110, 6'd0},   // R2 reset beats up step
        {3'b010, 6'd4},   // R4
        {3'b111, 6'd0},   // R2 reset beats down step
        {3'b001, 6'd0}    // R3
    };

    task automatic check(input string req, input logic [5:0] exp);
        n_run++;
        if (count !== exp) begin
            n_fail++;
            $display("FAIL %s: count=%0d expected=%0d", req, count, exp);
        end
    endtask

    task automatic step(input logic r, input logic e, input logic d);
        rst = r; evt = e; dir = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: state=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [5:0] model;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][8], VEC[i][7], VEC[i][6]);
            check("R1-table", VEC[i][5:0]);
        end

        // Full up lap from 0: R4, R6, R8
        step(1'b1, 1'b0, 1'b0);
        check("R1", 6'd0);
        model = 6'd0;
        for (int i = 0; i < 17; i++) begin
            step(1'b0, 1'b1, 1'b0);
            model = model + 6'd4;
            check("R4", model);
            n_run++;
            if (count[1:0] !== 2'b00) begin
                n_fail++;
                $display("FAIL R8: low=%0d expected=0", count[1:0]);
            end
        end

        // Full down lap: R5, R7, R8
        for (int i = 0; i < 18; i++) begin
            step(1'b0, 1'b1, 1'b1);
            model = model - 6'd4;
            check("R5", model);
            n_run++;
            if (count[1:0] !== 2'b00) begin
                n_fail++;
                $display("FAIL R8: low=%0d expected=0", count[1:0]);
            end
        end

        // Hold while dir toggles: R3
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b0, 1'(i));
            check("R3", model);
        end

        // Exact wrap corners: R6 and R7
        step(1'b1, 1'b0, 1'b0);
        check("R1", 6'd0);
        step(1'b0, 1'b1, 1'b1);
        check("R7", 6'd60);
        step(1'b0, 1'b1, 1'b0);
        check("R6", 6'd0);
        step(1'b1, 1'b1, 1'b1);
        check("R2", 6'd0);
        step(1'b0, 1'b0, 1'b0);
        check("R3", 6'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule